// File: doc/BRIEF.md
# Fixed Off-Time Mixed-Decay Bridge Regulator

This block is the digital control for one H-bridge winding under peak-current regulation. When enabled, it turns on the diagonal high-side/low-side pair that the direction bit selects. It holds that pair until an external current-sense comparator reports that the trip level has been reached. The comparator is not believed during a short window that opens at the start of every on-phase, because switching transients can make it fire falsely.

A trip starts an off-time of fixed length, counted in system clock ticks. The off-time has three parts. First comes fast decay, in which the opposite diagonal pair conducts as synchronous rectifiers, for a fixed fraction (about 30%) of the off-time. Next all four switches are off for a short dead time, which prevents shoot-through. The remainder is slow decay, in which both low-side switches recirculate the current. When the off-time ends, the bridge turns on again.

A zero-current detect input switches the rectifying transistors off for the rest of the off-time, so that the load current cannot reverse. A static select input chooses between a long and a short off-time variant. Dropping enable forces every switch off and returns the block to idle.

Top module: `mixdecay_ctrl`

## Requirements
- R1: With reset asserted, or one cycle after `en` has been sampled low in any state, all four gate outputs are 0. The block then waits in idle until `en` is high again.
- R2: The on-phase begins one cycle after `en` is sampled high in idle, or one cycle after an off-time ends. During the on-phase, `dir`=1 drives `hi_a` and `lo_b`, and `dir`=0 drives `hi_b` and `lo_a`. `dir` is sampled only at the start of each on-phase, so a change during the on-phase has no effect until the next one.
- R3: For the first BLANK_TICKS (default 1) cycles of every on-phase, `trip` is ignored. A trip that is present after that window ends the on-phase at the next clock edge.
- R4: Fast decay follows a trip. It drives the opposite diagonal: `hi_b`+`lo_a` for `dir`=1, and `hi_a`+`lo_b` for `dir`=0. It lasts round(off-time × 0.301) cycles, which is 2 for the short variant and 9 for the long one.
- R5: All four outputs are 0 for DEAD_TICKS (default 1) cycles between fast decay and slow decay.
- R6: Slow decay drives `lo_a` and `lo_b` for the rest of the off-time. The next on-phase follows directly after it, so the total off-time equals the selected tick count.
- R7: `short_sel`=1 selects an off-time of OFF_SHORT ticks (default 8). `short_sel`=0 selects OFF_LONG ticks (default 30), split into 9 cycles of fast decay, 1 of dead time and 20 of slow decay.
- R8: If `zero_det` is sampled high during any part of the off-time, all outputs are 0 from the next cycle until the off-time ends. The on-phase timing is unchanged.
- R9: `hi_a` and `lo_a` are never both 1, and `hi_b` and `lo_b` are never both 1.
- R10: `trip` has no effect outside the on-phase. It neither restarts nor shortens the off-time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one tick per timing count |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Bridge enable; low forces all outputs off |
| dir | input | 1 | Current direction, sampled at each on-phase start |
| trip | input | 1 | Current-sense comparator: trip level reached |
| zero_det | input | 1 | Load current has decayed to zero |
| short_sel | input | 1 | 1 = short off-time variant, 0 = long |
| hi_a | output | 1 | High-side gate enable, leg A |
| lo_a | output | 1 | Low-side gate enable, leg A |
| hi_b | output | 1 | High-side gate enable, leg B |
| lo_b | output | 1 | Low-side gate enable, leg B |

## Verification
The hardest case to reach from the ports is a zero-current detect that arrives inside fast decay and must keep the rectifiers off through the dead time and all of slow decay. The stimulus gets there by timing `zero_det` to the exact cycle after the trip, then watching every following cycle until the bridge turns back on. A second hard case is a trip held high through the blanking window and on into the off-time. The stimulus keeps `trip` high across those boundaries, so a design that checks `trip` too early or during decay would show a wrong output pattern. The long variant's 9/1/20 split is measured by counting cycles in each output pattern.

// File: rtl/mixdecay_pkg.sv
package mixdecay_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ON   = 3'd1,
        ST_FAST = 3'd2,
        ST_DEAD = 3'd3,
        ST_SLOW = 3'd4
    } mdc_state_e;

    typedef struct packed {
        logic hi_a;
        logic lo_a;
        logic hi_b;
        logic lo_b;
    } mdc_gate_t;

    function automatic int fast_share(input int off_ticks, input int permille);
        return (off_ticks * permille + 500) / 1000;
    endfunction

endpackage

// File: rtl/mixdecay_timer.sv
module mixdecay_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

    // R6: an expired count stays expired until reloaded
    p_hold_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && done) |=> done);

    // R6: a load of a nonzero value is not expired on the next cycle
    p_load_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !done);

endmodule

// File: rtl/mixdecay_gate_map.sv
module mixdecay_gate_map
    import mixdecay_pkg::*;
(
    input  mdc_state_e st,
    input  logic       dir_q,
    input  logic       zc_q,
    output mdc_gate_t  gate
);
    always_comb begin
        gate = '0;
        unique case (st)
            ST_ON: begin
                if (dir_q) begin gate.hi_a = 1'b1; gate.lo_b = 1'b1; end
                else       begin gate.hi_b = 1'b1; gate.lo_a = 1'b1; end
            end
            ST_FAST: begin
                if (!zc_q) begin
                    if (dir_q) begin gate.hi_b = 1'b1; gate.lo_a = 1'b1; end
                    else       begin gate.hi_a = 1'b1; gate.lo_b = 1'b1; end
                end
            end
            ST_SLOW: begin
                if (!zc_q) begin gate.lo_a = 1'b1; gate.lo_b = 1'b1; end
            end
            default: gate = '0;
        endcase
    end

    // R9: no leg has both switches on
    always_comb begin
        a_leg_a_r9: assert (!(gate.hi_a && gate.lo_a));
        a_leg_b_r9: assert (!(gate.hi_b && gate.lo_b));
    end

endmodule

// File: rtl/mixdecay_ctrl.sv
module mixdecay_ctrl
    import mixdecay_pkg::*;
#(
    parameter int OFF_LONG      = 30,
    parameter int OFF_SHORT     = 8,
    parameter int FAST_PERMILLE = 301,
    parameter int DEAD_TICKS    = 1,
    parameter int BLANK_TICKS   = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic dir,
    input  logic trip,
    input  logic zero_det,
    input  logic short_sel,
    output logic hi_a,
    output logic lo_a,
    output logic hi_b,
    output logic lo_b
);
    localparam int FAST_LONG  = fast_share(OFF_LONG, FAST_PERMILLE);
    localparam int FAST_SHORT = fast_share(OFF_SHORT, FAST_PERMILLE);
    localparam int SLOW_LONG  = OFF_LONG - FAST_LONG - DEAD_TICKS;
    localparam int SLOW_SHORT = OFF_SHORT - FAST_SHORT - DEAD_TICKS;
    localparam int MAX_OFF    = (OFF_LONG > OFF_SHORT) ? OFF_LONG : OFF_SHORT;
    localparam int MAX_TICKS  = (MAX_OFF > BLANK_TICKS) ? MAX_OFF : BLANK_TICKS;
    localparam int CW         = $clog2(MAX_TICKS + 1);

    typedef struct packed {
        mdc_state_e st;
        logic       dir;
        logic       zc;
    } ctrl_t;

    ctrl_t          r_d, r_q;
    logic           ph_load, ph_done, bl_load, bl_done;
    logic [CW-1:0]  ph_val;
    mdc_gate_t      gate;

    always_comb begin
        r_d     = r_q;
        ph_load = 1'b0;
        ph_val  = '0;
        bl_load = 1'b0;
        if (!en) begin
            r_d.st = ST_IDLE;
            r_d.zc = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    r_d.st  = ST_ON;
                    r_d.dir = dir;
                    r_d.zc  = 1'b0;
                    bl_load = 1'b1;
                end
                ST_ON: begin
                    if (bl_done && trip) begin
                        r_d.st  = ST_FAST;
                        ph_load = 1'b1;
                        ph_val  = short_sel ? CW'(FAST_SHORT - 1) : CW'(FAST_LONG - 1);
                    end
                end
                ST_FAST: begin
                    if (zero_det) r_d.zc = 1'b1;
                    if (ph_done) begin
                        r_d.st  = ST_DEAD;
                        ph_load = 1'b1;
                        ph_val  = CW'(DEAD_TICKS - 1);
                    end
                end
                ST_DEAD: begin
                    if (zero_det) r_d.zc = 1'b1;
                    if (ph_done) begin
                        r_d.st  = ST_SLOW;
                        ph_load = 1'b1;
                        ph_val  = short_sel ? CW'(SLOW_SHORT - 1) : CW'(SLOW_LONG - 1);
                    end
                end
                ST_SLOW: begin
                    if (zero_det) r_d.zc = 1'b1;
                    if (ph_done) begin
                        r_d.st  = ST_ON;
                        r_d.dir = dir;
                        r_d.zc  = 1'b0;
                        bl_load = 1'b1;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, dir: 1'b0, zc: 1'b0};
        else        r_q <= r_d;
    end

    mixdecay_timer #(.W(CW)) u_phase (
        .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .done(ph_done)
    );

    mixdecay_timer #(.W(CW)) u_blank (
        .clk(clk), .rst_n(rst_n), .load(bl_load), .load_val(CW'(BLANK_TICKS)), .done(bl_done)
    );

    mixdecay_gate_map u_map (
        .st(r_q.st), .dir_q(r_q.dir), .zc_q(r_q.zc), .gate(gate)
    );

    assign hi_a = gate.hi_a;
    assign lo_a = gate.lo_a;
    assign hi_b = gate.hi_b;
    assign lo_b = gate.lo_b;

    // R1: enable low turns every switch off on the next cycle
    p_en_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !(hi_a || lo_a || hi_b || lo_b));

    // R3: a trip inside the blanking window keeps the on-phase
    p_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && r_q.st == ST_ON && !bl_done) |=> r_q.st == ST_ON);

    // R5: dead time always separates fast decay from slow decay
    p_dead_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SLOW && $past(r_q.st) != ST_SLOW) |-> $past(r_q.st) == ST_DEAD);

    // R8: once zero current is seen, no switch conducts during the off-time
    p_zero_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.zc && r_q.st != ST_ON) |-> !(hi_a || lo_a || hi_b || lo_b));

    // R10: off-time phases move forward only, never back into fast decay
    p_no_retrig_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DEAD || r_q.st == ST_SLOW) |=> r_q.st != ST_FAST);

endmodule

// File: tb/mixdecay_ctrl_bench.sv
module mixdecay_ctrl_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, dir = 1'b0, trip = 1'b0, zero_det = 1'b0, short_sel = 1'b1;
    logic hi_a, lo_a, hi_b, lo_b;
    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;

    always #4 clk = ~clk;

    mixdecay_ctrl u_mixdecay_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .dir(dir), .trip(trip),
        .zero_det(zero_det), .short_sel(short_sel),
        .hi_a(hi_a), .lo_a(lo_a), .hi_b(hi_b), .lo_b(lo_b)
    );

    // Gate pattern order {hi_a, lo_a, hi_b, lo_b}
    localparam logic [3:0] G_OFF = 4'b0000;
    localparam logic [3:0] G_FWD = 4'b1001;
    localparam logic [3:0] G_REV = 4'b0110;
    localparam logic [3:0] G_LOW = 4'b0101;

    // {req[12:9], en, dir, trip, zero_det, short_sel, expected gates}
    localparam int NV = 42;
    localparam logic [12:0] VEC [NV] = '{
        {4'd2,  5'b11001, G_FWD},  // R2 forward on
        {4'd3,  5'b11101, G_FWD},  // R3 trip blanked
        {4'd4,  5'b11101, G_REV},  // R4 fast decay
        {4'd10, 5'b11101, G_REV},  // R10 trip in fast ignored
        {4'd5,  5'b11001, G_OFF},  // R5 dead time
        {4'd10, 5'b11101, G_LOW},  // R10 trip in dead ignored
        {4'd6,  5'b11001, G_LOW},  // R6 slow
        {4'd6,  5'b11001, G_LOW},
        {4'd6,  5'b11001, G_LOW},
        {4'd6,  5'b11001, G_LOW},
        {4'd7,  5'b11001, G_FWD},  // R7 short off-time of 8 ends
        {4'd3,  5'b11101, G_FWD},  // R3 blank again
        {4'd4,  5'b11101, G_REV},
        {4'd8,  5'b11011, G_OFF},  // R8 zero in fast
        {4'd5,  5'b11001, G_OFF},
        {4'd8,  5'b11001, G_OFF},  // R8 slow suppressed
        {4'd8,  5'b11001, G_OFF},
        {4'd8,  5'b11001, G_OFF},
        {4'd8,  5'b11001, G_OFF},
        {4'd8,  5'b11001, G_OFF},
        {4'd6,  5'b11001, G_FWD},  // R6 back on
        {4'd2,  5'b10001, G_FWD},  // R2 dir change mid on ignored
        {4'd1,  5'b00001, G_OFF},  // R1 disable
        {4'd2,  5'b10001, G_REV},  // R2 reverse on
        {4'd3,  5'b10101, G_REV},
        {4'd4,  5'b10101, G_FWD},  // R4 reverse fast
        {4'd4,  5'b10001, G_FWD},
        {4'd5,  5'b10001, G_OFF},
        {4'd6,  5'b10001, G_LOW},
        {4'd1,  5'b00001, G_OFF},  // R1 disable in slow
        {4'd2,  5'b11001, G_FWD},
        {4'd3,  5'b11101, G_FWD},
        {4'd4,  5'b11101, G_REV},
        {4'd4,  5'b11001, G_REV},
        {4'd5,  5'b11001, G_OFF},
        {4'd6,  5'b11001, G_LOW},
        {4'd8,  5'b11011, G_OFF},  // R8 zero in slow
        {4'd8,  5'b11001, G_OFF},
        {4'd8,  5'b11001, G_OFF},
        {4'd8,  5'b11001, G_OFF},
        {4'd6,  5'b11001, G_FWD},
        {4'd1,  5'b00001, G_OFF}
    };

    function automatic logic [3:0] gates();
        return {hi_a, lo_a, hi_b, lo_b};
    endfunction

    task automatic check(input string req, input logic [3:0] exp_g, input string what);
        total++;
        if (gates() !== exp_g) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, gates(), exp_g);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp_v, input string what);
        total++;
        if (act != exp_v) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp_v);
        end
    endtask

    // R9 watched on every cycle
    always @(negedge clk) begin
        if (rst_n && ((hi_a && lo_a) || (hi_b && lo_b))) begin
            bad++;
            total++;
            $display("FAIL R9 shoot-through: actual=%b expected=no leg 11", gates());
        end
    end

    task automatic count_pattern(input logic [3:0] pat, output int n);
        n = 0;
        while (gates() === pat && n < 100) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check("R1", G_OFF, "during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", G_OFF, "idle after reset with en low");

        for (int i = 0; i < NV; i++) begin
            {en, dir, trip, zero_det, short_sel} = VEC[i][8:4];
            @(negedge clk);
            total++;
            if (gates() !== VEC[i][3:0]) begin
                bad++;
                $display("FAIL R%0d row %0d: actual=%b expected=%b",
                         VEC[i][12:9], i, gates(), VEC[i][3:0]);
            end
        end

        // R7 long variant: 9 fast, 1 dead, 20 slow
        short_sel = 1'b0; dir = 1'b1; trip = 1'b0; zero_det = 1'b0; en = 1'b1;
        @(negedge clk);
        check("R7", G_FWD, "long variant on");
        trip = 1'b1;
        @(negedge clk);
        @(negedge clk);
        trip = 1'b0;
        count_pattern(G_REV, n);
        check_int("R7", n, 9, "long fast-decay cycles");
        count_pattern(G_OFF, n);
        check_int("R5", n, 1, "long dead cycles");
        count_pattern(G_LOW, n);
        check_int("R7", n, 20, "long slow-decay cycles");
        check("R6", G_FWD, "on after long off-time");

        // R1 reset mid-run
        trip = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", G_OFF, "async reset in fast decay");
        @(negedge clk);
        rst_n = 1'b1;
        trip = 1'b0;
        @(negedge clk);
        check("R2", G_FWD, "fresh on after reset");
        @(negedge clk);
        check("R3", G_FWD, "no trip stays on");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule